// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This unit adds with carry or subtracts with borrow two 16-bit operands. It works either as plain binary or as packed decimal, where each 4-bit digit holds a value from 0 to 9. A decimal-mode input picks the number system. A length input picks the width of the operation: the full 16 bits (four decimal digits) or the low byte only (two decimal digits). Decimal correction is done inside the same operation, digit by digit, and the correction of one digit feeds the carry or borrow chain into the next. No separate adjust step is needed.

The result and all flags are captured in registers, so they appear one clock after the operands are presented. A new operation can be started on every cycle. The flag register is kept by the caller. The unit only supplies the next values: carry (or no-borrow), zero, negative and signed overflow. It also supplies a qualifier that marks the zero flag as meaningless after a decimal addition.

Top module: `dual_radix_addsub`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: Every output reflects the inputs sampled at the previous rising edge. Back-to-back operations are accepted on every cycle.
- R3: With `dec_mode`=0 and `op_sub`=0, the result is A + B + `carry_in`, taken modulo 2^W. `carry_out` is the carry out of bit W-1.
- R4: With `dec_mode`=0 and `op_sub`=1, the result is A - B - (1 - `carry_in`), taken modulo 2^W. A carry-in of 1 means no borrow. `carry_out` is 1 when no borrow occurred and 0 when one did.
- R5: With `byte_mode`=1, W=8 and only bits 7:0 are operated on. Bits 15:8 of the result equal bits 15:8 of A, and every flag is taken at bit 7. With `byte_mode`=0, W=16.
- R6: With `dec_mode`=1 and `op_sub`=0, the operands are packed decimal, with digit 0 in bits 3:0. The result is the decimal sum plus `carry_in`, taken modulo 100 (byte) or 10000 (word). `carry_out` is 1 when that sum reached the modulus.
- R7: With `dec_mode`=1 and `op_sub`=1, the result is the decimal difference A - B - (1 - `carry_in`), wrapped by adding 100 or 10000 when it is negative. `carry_out` is 0 exactly when a wrap happened.
- R8: `neg` equals result bit W-1.
- R9: `zero` is 1 exactly when result bits W-1:0 are all 0.
- R10: `zero_ok` is 0 after a decimal addition and 1 after every other operation.
- R11: In binary mode, `ovf` is 1 exactly when the operation overflows as a two's complement operation at width W. In decimal mode, `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 16 | Operand A (minuend for subtraction) |
| opb | input | 16 | Operand B (subtrahend for subtraction) |
| carry_in | input | 1 | Carry for add; 1 = no borrow for subtract |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 0 = binary, 1 = packed decimal |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Carry (add) or no-borrow (subtract) |
| zero | output | 1 | Active-width result is zero |
| neg | output | 1 | Top active result bit |
| ovf | output | 1 | Signed overflow, binary only |
| zero_ok | output | 1 | Zero flag is meaningful |

## Verification
The sharpest overlap is a decimal addition in byte mode that wraps to zero. In that one cycle, digit correction must ripple a carry out of digit 1 and not digit 3. The upper byte must pass through, `zero` must still report the all-zero low byte, and `zero_ok` must drop. The bench provokes this with 0x99 + 0x01 under a nonzero upper byte of A. It judges every output field against values derived from integer decimal arithmetic, not digit rules. A second overlap, a decimal borrow that ripples through all four digits (0000 - 0001), is checked the same way.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DEC_FIX = 4'd6;
  localparam logic [DIGIT_W:0]   DEC_MAX = 5'd9;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
    logic zero_ok;
  } flags_t;
endpackage

// File: rtl/addsub_digit.sv
module addsub_digit
  import addsub_pkg::*;
(
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b_eff,
  input  logic               ci,
  input  logic               dec,
  input  logic               sub,
  output logic [DIGIT_W-1:0] r,
  output logic               co
);
  logic [DIGIT_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b_eff} + {{DIGIT_W{1'b0}}, ci};
    r   = raw[DIGIT_W-1:0];
    co  = raw[DIGIT_W];
    if (dec) begin
      if (!sub) begin
        // digit above nine: step past the six unused codes, carry on
        if (raw > DEC_MAX) begin
          r  = raw[DIGIT_W-1:0] + DEC_FIX;
          co = 1'b1;
        end
      end else if (!raw[DIGIT_W]) begin
        // digit borrowed: remove the six unused codes
        r = raw[DIGIT_W-1:0] - DEC_FIX;
      end
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_eff,
  input  logic [DATA_W-1:0] sum,
  input  logic              carry_half,
  input  logic              carry_full,
  input  logic              byte_sel,
  input  logic              dec,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output flags_t            flg
);
  localparam int HALF = DATA_W / 2;

  logic a_t, b_t, s_t;

  always_comb begin
    a_t = byte_sel ? a[HALF-1]     : a[DATA_W-1];
    b_t = byte_sel ? b_eff[HALF-1] : b_eff[DATA_W-1];
    s_t = byte_sel ? sum[HALF-1]   : sum[DATA_W-1];
    res = byte_sel ? {a[DATA_W-1:HALF], sum[HALF-1:0]} : sum;
    flg.carry   = byte_sel ? carry_half : carry_full;
    flg.zero    = byte_sel ? (sum[HALF-1:0] == '0) : (sum == '0);
    flg.neg     = s_t;
    flg.ovf     = !dec && (a_t == b_t) && (s_t != a_t);
    flg.zero_ok = !(dec && !sub);
  end
endmodule

// File: rtl/dual_radix_addsub.sv
module dual_radix_addsub
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  input  logic              op_sub,
  input  logic              dec_mode,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              zero,
  output logic              neg,
  output logic              ovf,
  output logic              zero_ok
);
  localparam int NDIG     = DATA_W / DIGIT_W;
  localparam int HALF_DIG = NDIG / 2;
  localparam int HALF     = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic [NDIG:0]     chain;
  logic [DATA_W-1:0] res_d;
  flags_t            flg_d;
  flags_t            flg_q;
  logic [DATA_W-1:0] res_q;

  assign b_eff    = op_sub ? ~opb : opb;
  assign chain[0] = carry_in;

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_dig
      addsub_digit u_dig (
        .a    (opa[g*DIGIT_W +: DIGIT_W]),
        .b_eff(b_eff[g*DIGIT_W +: DIGIT_W]),
        .ci   (chain[g]),
        .dec  (dec_mode),
        .sub  (op_sub),
        .r    (sum[g*DIGIT_W +: DIGIT_W]),
        .co   (chain[g+1])
      );

      // R6: valid decimal digits added give a valid decimal digit
      assert_digit_range_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_mode && !op_sub &&
         opa[g*DIGIT_W +: DIGIT_W] <= 4'd9 && opb[g*DIGIT_W +: DIGIT_W] <= 4'd9)
        |-> (sum[g*DIGIT_W +: DIGIT_W] <= 4'd9));
    end
  endgenerate

  addsub_flags #(.DATA_W(DATA_W)) u_flags (
    .a         (opa),
    .b_eff     (b_eff),
    .sum       (sum),
    .carry_half(chain[HALF_DIG]),
    .carry_full(chain[NDIG]),
    .byte_sel  (byte_mode),
    .dec       (dec_mode),
    .sub       (op_sub),
    .res       (res_d),
    .flg       (flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result    = res_q;
  assign carry_out = flg_q.carry;
  assign zero      = flg_q.zero;
  assign neg       = flg_q.neg;
  assign ovf       = flg_q.ovf;
  assign zero_ok   = flg_q.zero_ok;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out && !zero && !neg && !ovf && !zero_ok));

  assert_upper_pass_R5: assert property (@(posedge clk) disable iff (rst)
    byte_mode |=> (result[DATA_W-1:HALF] == $past(opa[DATA_W-1:HALF])));

  assert_neg_byte_R8: assert property (@(posedge clk) disable iff (rst)
    byte_mode |=> (neg == result[HALF-1]));

  assert_neg_word_R8: assert property (@(posedge clk) disable iff (rst)
    !byte_mode |=> (neg == result[DATA_W-1]));

  assert_zero_match_R9: assert property (@(posedge clk) disable iff (rst)
    !byte_mode |=> (zero == (result == '0)));

  assert_zero_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (dec_mode && !op_sub) |=> !zero_ok);

  assert_dec_no_ovf_R11: assert property (@(posedge clk) disable iff (rst)
    dec_mode |=> !ovf);
endmodule

// File: tb/dual_radix_addsub_test.sv
module dual_radix_addsub_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opa, opb;
  logic        carry_in, op_sub, dec_mode, byte_mode;
  logic [15:0] result;
  logic        carry_out, zero, neg, ovf, zero_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_radix_addsub uut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .carry_in(carry_in),
    .op_sub(op_sub), .dec_mode(dec_mode), .byte_mode(byte_mode),
    .result(result), .carry_out(carry_out), .zero(zero), .neg(neg),
    .ovf(ovf), .zero_ok(zero_ok)
  );

  function automatic int bcd_to_int(input logic [15:0] v, input int nd);
    int acc = 0;
    for (int i = nd - 1; i >= 0; i--) acc = acc * 10 + int'(v[i*4 +: 4]);
    return acc;
  endfunction

  function automatic logic [15:0] int_to_bcd(input int v, input int nd);
    logic [15:0] o = '0;
    int t = v;
    for (int i = 0; i < nd; i++) begin
      o[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return o;
  endfunction

  // expected = {result, carry, zero, neg, ovf, zero_ok}
  function automatic logic [20:0] model(input logic [15:0] a, input logic [15:0] b,
      input logic ci, input logic sub, input logic dec, input logic b8);
    int w = b8 ? 8 : 16;
    int mask = (1 << w) - 1;
    int s;
    logic co, v;
    logic [15:0] sv, r;
    v = 1'b0;
    if (!dec) begin
      int aa = int'(a) & mask;
      int bb = int'(b) & mask;
      logic sa, sb, sr;
      if (!sub) begin s = aa + bb + int'(ci); co = ((s >> w) & 1) != 0; end
      else begin s = aa - bb - (ci ? 0 : 1); co = (s >= 0); end
      s = s & mask;
      sa = ((aa >> (w-1)) & 1) != 0;
      sb = ((bb >> (w-1)) & 1) != 0;
      if (sub) sb = !sb;
      sr = ((s >> (w-1)) & 1) != 0;
      v = (sa == sb) && (sr != sa);
      sv = 16'(s);
    end else begin
      int nd = w / 4;
      int lim = b8 ? 100 : 10000;
      int da = bcd_to_int(a, nd);
      int db = bcd_to_int(b, nd);
      if (!sub) begin
        s = da + db + int'(ci); co = (s >= lim); if (co) s = s - lim;
      end else begin
        s = da - db - (ci ? 0 : 1); co = (s >= 0); if (!co) s = s + lim;
      end
      sv = int_to_bcd(s, nd);
    end
    r = b8 ? {a[15:8], sv[7:0]} : sv;
    return {r, co, (b8 ? (r[7:0] == 8'h00) : (r == 16'h0)),
            (b8 ? r[7] : r[15]), v, !(dec && !sub)};
  endfunction

  task automatic check(input string tag, input logic [20:0] exp);
    logic [20:0] act = {result, carry_out, zero, neg, ovf, zero_ok};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual res=%h c=%b z=%b n=%b v=%b zok=%b expected res=%h c=%b z=%b n=%b v=%b zok=%b",
               tag, act[20:5], act[4], act[3], act[2], act[1], act[0],
               exp[20:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic ci,
      input logic sub, input logic dec, input logic b8);
    opa = a; opb = b; carry_in = ci; op_sub = sub; dec_mode = dec; byte_mode = b8;
  endtask

  task automatic apply(input string tag, input logic [15:0] a, input logic [15:0] b,
      input logic ci, input logic sub, input logic dec, input logic b8);
    @(negedge clk);
    drive(a, b, ci, sub, dec, b8);
    @(negedge clk);
    check(tag, model(a, b, ci, sub, dec, b8));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset state", 21'b0);
    rst = 1'b0;
  endtask

  task automatic t_bin_add();
    apply("R3 plain add",          16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R3 R9 wrap to zero",    16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R3 R11 R8 pos ovf",     16'h7FFF, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 R11 neg ovf",        16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bin_sub();
    apply("R4 no borrow",          16'h5000, 16'h1000, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R4 R8 borrow",          16'h1000, 16'h2000, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R4 borrow in",          16'h0005, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R4 R11 ovf",            16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_byte();
    apply("R5 byte add carry",     16'hAB12, 16'h34F0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R5 R11 byte sub ovf",   16'h5580, 16'hFF01, 1'b1, 1'b1, 1'b0, 1'b1);
    apply("R5 R9 byte zero",       16'hC300, 16'h7700, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_dec_add();
    apply("R6 R10 word",           16'h1234, 16'h5678, 1'b0, 1'b0, 1'b1, 1'b0);
    apply("R6 R9 R10 word wrap",   16'h9999, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0);
    apply("R6 R5 R10 byte wrap",   16'hC399, 16'h1201, 1'b0, 1'b0, 1'b1, 1'b1);
    apply("R6 R11 digit carries",  16'h0958, 16'h0047, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_dec_sub();
    apply("R7 word",               16'h1000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
    apply("R7 full borrow",        16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
    apply("R7 R5 byte borrow in",  16'h7750, 16'h0025, 1'b0, 1'b1, 1'b1, 1'b1);
    apply("R7 R10 zero result",    16'h4321, 16'h4321, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_stream();
    logic [20:0] e1, e2;
    e1 = model(16'h0102, 16'h0304, 1'b0, 1'b0, 1'b0, 1'b0);
    e2 = model(16'h0099, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); drive(16'h0102, 16'h0304, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); check("R2 first of pair", e1);
    drive(16'h0099, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); check("R2 second of pair", e2);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 300; i++) begin
      logic dec, sub, b8, ci;
      logic [15:0] a, b;
      dec = 1'($urandom); sub = 1'($urandom); b8 = 1'($urandom); ci = 1'($urandom);
      if (dec) begin
        a = int_to_bcd(int'($urandom % 10000), 4);
        b = int_to_bcd(int'($urandom % 10000), 4);
      end else begin
        a = 16'($urandom); b = 16'($urandom);
      end
      apply(dec ? (sub ? "R7 sweep" : "R6 sweep") : (sub ? "R4 sweep" : "R3 sweep"),
            a, b, ci, sub, dec, b8);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bin_add();
    t_bin_sub();
    t_byte();
    t_dec_add();
    t_dec_sub();
    t_stream();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule